// File: doc/BRIEF.md
# Reloadable Constant-Coefficient Multiplier

This block scales a stream of 16-bit unsigned samples by a constant that can be changed at run time. It has no general multiplier. Every sample is cut into four 4-bit nibbles. Each nibble selects an entry from a 16-entry table that holds the multiples 0·C to 15·C of the current constant. The four partial products are shifted by their nibble weight and added in a two-level registered adder tree. A new 32-bit product appears a fixed three clock edges after the sample is taken, and the block accepts one sample every cycle.

To change the constant, the client presents it with a one-cycle load request. The block then rebuilds the table itself. A repeated-add accumulator starts from zero and adds the constant once per cycle. Each accumulator value is pushed into a shift-register table, and the last sixteen values pushed make up the table contents. While this runs, a busy flag is high for sixteen cycles. Samples offered during that time are dropped, and so is any further load request.

Top module: `nibble_scaler`

## Requirements
- R1: After reset, `out_valid` and `busy` are 0 and `out_prod` is 0. The table holds zeros, so a sample taken before the first reload yields a product of 0.
- R2: For an accepted sample S and current constant C, `out_prod` equals S×C as a 32-bit unsigned value.
- R3: A sample taken at a rising edge with `in_valid`=1 and `busy`=0 gives `out_valid`=1 for exactly one cycle, starting after the third rising edge counted from that edge. Samples offered on consecutive cycles give products on consecutive cycles, in the same order.
- R4: A `load_req` sampled while `busy`=0 sets `busy` at that edge. `busy` then stays high for exactly 16 cycles.
- R5: A sample offered while `busy`=1 produces no `out_valid` pulse.
- R6: A `load_req` sampled while `busy`=1 is ignored. It does not lengthen the busy window, and the constant already being loaded stays in force.
- R7: After a reload with constant C, each nibble value n (0..15) in any of the four nibble positions (bits 3:0, 7:4, 11:8, 15:12, weighted 1, 16, 256 and 4096) contributes n×C times that weight.
- R8: A sample accepted in the same cycle as an accepted `load_req` is multiplied by the previous constant.
- R9: The extreme constants give exact results: C=0 gives 0, and C=0xFFFF with S=0xFFFF gives 0xFFFE0001.
- R10: While `out_valid` is 0, `out_prod` keeps the last product it showed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Unsigned sample |
| load_req | input | 1 | Request to load `coef_in` as the new constant |
| coef_in | input | 16 | New constant, sampled with `load_req` |
| busy | output | 1 | High while the table is being rebuilt |
| out_valid | output | 1 | Product strobe |
| out_prod | output | 32 | Unsigned product |

## Verification
The assertions assume two things about the inputs: samples offered during a reload are discarded, and the constant is read only in the cycle its load request is accepted. They then check the sixteen-step accumulator walk and the fixed three-edge path from an accepted sample to its product. The stimulus offers samples only at times whose outcome is fully defined. It sweeps every nibble value through every nibble position after a reload, and it holds `in_valid` and a second `load_req` active inside the busy window, so that the dropping rules are exercised on purpose rather than by chance.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_FILL = 1'b1
    } ld_state_e;

    // Position in the shift table that holds nibble value n times the constant.
    // The newest push sits at slot 0, so value n sits at slot depth-1-n.
    function automatic int unsigned slot_of(input int unsigned n, input int unsigned depth);
        return depth - 1 - n;
    endfunction
endpackage

// File: rtl/scl_coef_loader.sv
module scl_coef_loader
    import scl_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_req,
    input  logic [COEF_W-1:0]       coef_in,
    output logic                    busy,
    output logic                    push,
    output logic [COEF_W+NIB_W-1:0] push_val
);
    localparam int DEPTH = 2 ** NIB_W;
    localparam int ENT_W = COEF_W + NIB_W;
    localparam logic [NIB_W-1:0] LAST = NIB_W'(DEPTH - 1);

    typedef struct packed {
        ld_state_e         state;
        logic [NIB_W-1:0]  cnt;
        logic [COEF_W-1:0] coef;
        logic [ENT_W-1:0]  acc;
    } ld_reg_t;

    ld_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            LD_IDLE: begin
                if (load_req) begin
                    r_d.state = LD_FILL;
                    r_d.cnt   = '0;
                    r_d.acc   = '0;
                    r_d.coef  = coef_in;
                end
            end
            LD_FILL: begin
                r_d.acc = r_q.acc + ENT_W'(r_q.coef);
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.state = LD_IDLE;
                end
            end
            default: r_d.state = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: LD_IDLE, cnt: '0, coef: '0, acc: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state == LD_FILL);
    assign push     = busy;
    assign push_val = r_q.acc;

    // R4: the fill window ends after its sixteenth push
    assert_fill_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LD_FILL && r_q.cnt == LAST) |=> (r_q.state == LD_IDLE));

    // R4: every fill starts from a cleared accumulator and count
    assert_fill_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (r_q.acc == '0 && r_q.cnt == '0));

    // R6: a request during a fill leaves the captured constant untouched
    assert_req_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_req) |=> $stable(r_q.coef));

    // R7: successive pushed values differ by exactly the constant
    assert_acc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.cnt != '0) |-> (r_q.acc == $past(r_q.acc) + ENT_W'(r_q.coef)));
endmodule

// File: rtl/scl_shift_table.sv
module scl_shift_table
    import scl_pkg::*;
#(
    parameter int ENT_W   = 20,
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                push,
    input  logic [ENT_W-1:0]                    push_val,
    input  logic [NUM_NIB*NIB_W-1:0]            sample,
    output logic [NUM_NIB-1:0][ENT_W-1:0]       rd
);
    localparam int DEPTH = 2 ** NIB_W;

    typedef logic [DEPTH-1:0][ENT_W-1:0] tab_t;

    tab_t tab_q, tab_d;

    always_comb begin
        tab_d = tab_q;
        if (push) begin
            tab_d[0] = push_val;
            for (int i = 1; i < DEPTH; i++) begin
                tab_d[i] = tab_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    for (genvar k = 0; k < NUM_NIB; k++) begin : g_port
        logic [NIB_W-1:0] nib;
        assign nib   = sample[k*NIB_W +: NIB_W];
        assign rd[k] = tab_q[NIB_W'(slot_of(32'(nib), DEPTH))];
    end

    // R7: a push lands at slot 0 and the older entries move up one slot
    assert_push_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (tab_q[0] == $past(push_val) && tab_q[1] == $past(tab_q[0])));

    // R7: with no push the table contents stay frozen
    assert_table_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(tab_q));
endmodule

// File: rtl/scl_add_tree.sv
module scl_add_tree #(
    parameter int ENT_W   = 20,
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 4,
    parameter int PROD_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take,
    input  logic [NUM_NIB-1:0][ENT_W-1:0] pp_in,
    output logic                          out_valid,
    output logic [PROD_W-1:0]             out_prod
);
    localparam int NUM_PAIR = NUM_NIB / 2;
    localparam int PAIR_W   = ENT_W + NIB_W;
    localparam int PAIR_SH  = 2 * NIB_W;

    typedef struct packed {
        logic                           v1;
        logic [NUM_NIB-1:0][ENT_W-1:0]  pp;
        logic                           v2;
        logic [NUM_PAIR-1:0][PAIR_W-1:0] pair;
        logic                           v3;
        logic [PROD_W-1:0]              prod;
    } tree_reg_t;

    tree_reg_t t_q, t_d;
    logic [NUM_PAIR-1:0][PAIR_W-1:0] pair_sum;

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign pair_sum[p] = PAIR_W'(t_q.pp[2*p])
                           + (PAIR_W'(t_q.pp[2*p+1]) << NIB_W);
    end

    always_comb begin
        t_d    = t_q;
        t_d.v1 = take;
        if (take) begin
            t_d.pp = pp_in;
        end
        t_d.v2 = t_q.v1;
        if (t_q.v1) begin
            t_d.pair = pair_sum;
        end
        t_d.v3 = t_q.v2;
        if (t_q.v2) begin
            t_d.prod = PROD_W'(t_q.pair[0]) + (PROD_W'(t_q.pair[1]) << PAIR_SH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign out_valid = t_q.v3;
    assign out_prod  = t_q.prod;

    // R3: a taken sample walks through both adder levels without loss
    assert_level1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.v1 |=> t_q.v2);
    assert_level2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.v2 |=> t_q.v3);

    // R10: the product register holds when no sum reaches it
    assert_prod_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !t_q.v2 |=> $stable(t_q.prod));
endmodule

// File: rtl/nibble_scaler.sv
module nibble_scaler #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_sample,
    input  logic                     load_req,
    input  logic [COEF_W-1:0]        coef_in,
    output logic                     busy,
    output logic                     out_valid,
    output logic [DATA_W+COEF_W-1:0] out_prod
);
    localparam int NUM_NIB = DATA_W / NIB_W;
    localparam int ENT_W   = COEF_W + NIB_W;
    localparam int PROD_W  = DATA_W + COEF_W;

    logic                          push;
    logic [ENT_W-1:0]              push_val;
    logic [NUM_NIB-1:0][ENT_W-1:0] rd;
    logic                          take;

    scl_coef_loader #(.COEF_W(COEF_W), .NIB_W(NIB_W)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .coef_in  (coef_in),
        .busy     (busy),
        .push     (push),
        .push_val (push_val)
    );

    scl_shift_table #(.ENT_W(ENT_W), .NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_val (push_val),
        .sample   (in_sample),
        .rd       (rd)
    );

    assign take = in_valid && !busy;

    scl_add_tree #(.ENT_W(ENT_W), .NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .PROD_W(PROD_W)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .pp_in     (rd),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    // R3: an accepted sample yields a product strobe three edges later
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |-> ##3 out_valid);

    // R5: a sample offered during a reload never produces a strobe
    assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy) |-> ##3 !out_valid);

    // R4: a request taken while idle raises busy at the next edge
    assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !busy) |=> busy);
endmodule

// File: tb/nibble_scaler_tb.sv
module nibble_scaler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // each entry: {constant, sample}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0003, 16'h0000}, {16'h0003, 16'h1234}, {16'h0003, 16'hFFFF},
        {16'h00A7, 16'h8001}, {16'h00A7, 16'h0F0F}, {16'hFFFF, 16'hFFFF},
        {16'hFFFF, 16'h0001}, {16'h0000, 16'hABCD}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [15:0] in_sample = 0;
    logic        load_req = 0;
    logic [15:0] coef_in = 0;
    logic        busy, out_valid;
    logic [31:0] out_prod;

    int checks = 0;
    int fails = 0;
    logic [15:0] cur_coef = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_scaler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .load_req(load_req), .coef_in(coef_in), .busy(busy),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reload; optionally offer junk samples and a second request while busy.
    task automatic reload(input logic [15:0] c, input bit junk, input bit extra);
        int n = 0;
        @(negedge clk);
        load_req = 1; coef_in = c;
        @(negedge clk);
        load_req = 0;
        while (busy) begin
            n++;
            in_valid  = junk;
            in_sample = 16'hFFFF - 16'(n);
            load_req  = extra && (n == 5);
            coef_in   = 16'h1234;
            if (junk) check("R5 no strobe while busy", 32'(out_valid), 0);
            @(negedge clk);
        end
        in_valid = 0; load_req = 0;
        check(extra ? "R6 busy length with extra request" : "R4 busy length", n, 16);
        for (int i = 0; i < 3; i++) begin
            if (junk) check("R5 no strobe after busy", 32'(out_valid), 0);
            @(negedge clk);
        end
        cur_coef = c;
    endtask

    task automatic single(input logic [15:0] s, input logic [31:0] exp, input string req);
        @(negedge clk);
        in_valid = 1; in_sample = s;
        @(negedge clk);
        in_valid = 0;
        check({req, " no early strobe"}, 32'(out_valid), 0);
        @(negedge clk);
        @(negedge clk);
        check({req, " strobe"}, 32'(out_valid), 1);
        check({req, " product"}, out_prod, exp);
        @(negedge clk);
        check({req, " single-cycle strobe"}, 32'(out_valid), 0);
        check("R10 product held", out_prod, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy at reset", 32'(busy), 0);
        check("R1 out_valid at reset", 32'(out_valid), 0);
        check("R1 product at reset", out_prod, 0);
        rst_n = 1;
        single(16'h1234, 0, "R1 empty table");

        // R2 R9 vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] c = VEC[v][31:16];
            logic [15:0] s = VEC[v][15:0];
            if (v == 0 || c != cur_coef) reload(c, 0, 0);
            single(s, 32'(c) * 32'(s), (c == 0 || c == 16'hFFFF) ? "R9" : "R2");
        end

        // R7: every nibble value in every position
        reload(16'h1357, 0, 0);
        for (int k = 0; k < 16; k++) begin
            single(16'(k * 16'h1111), 32'h1357 * 32'(k * 16'h1111), "R7");
        end

        // R3: back-to-back samples
        begin
            logic [15:0] bs [4] = '{16'h0001, 16'hFFFF, 16'h8000, 16'h00F0};
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                if (j >= 3 && j < 7) begin
                    check("R3 back-to-back strobe", 32'(out_valid), 1);
                    check("R3 back-to-back product", out_prod, 32'h1357 * 32'(bs[j-3]));
                end else begin
                    check("R3 idle strobe", 32'(out_valid), 0);
                end
                in_valid  = (j < 4);
                in_sample = (j < 4) ? bs[j] : 16'h0;
            end
            in_valid = 0;
        end

        // R5 and R6: junk samples and a second request during reload
        reload(16'h0042, 1, 1);
        single(16'h0100, 32'h0042 * 32'h0100, "R6 first constant kept");

        // R8: sample taken with the load request uses the old constant
        @(negedge clk);
        in_valid = 1; in_sample = 16'h0203;
        load_req = 1; coef_in = 16'h0777;
        @(negedge clk);
        in_valid = 0; load_req = 0;
        @(negedge clk);
        @(negedge clk);
        check("R8 strobe", 32'(out_valid), 1);
        check("R8 old constant product", out_prod, 32'h0042 * 32'h0203);
        while (busy) @(negedge clk);
        single(16'h0203, 32'h0777 * 32'h0203, "R8 new constant after reload");

        finish_run();
    end
endmodule